// File: doc/BRIEF.md
# Dual-Port Synchronous Pipelined Byte-Lane RAM

This block is a shared word store with two fully independent access ports, A and B. Each port can read or write any word in the array. A word holds two byte lanes of nine bits, and the number of words is set by a parameter. Every port input is captured in a register on the rising clock edge. The array is accessed on the following edge, and a read lands in an output register. The port's output therefore shows the data two edges after the request was presented.

Each port has its own burst address counter. The counter can be cleared, loaded from the address pins, advanced by one with wrap-around, or held, so that bursts can be stalled for interleaved traffic. The port is selected by a pair of chip selects: one is active low, the other active high. Two instances can be banked in depth by routing the top address bit to the low-active select of one instance and the high-active select of the other. When a port is not selected, it neither reads nor writes and its counter holds. Output drive is flagged rather than tri-stated, and it follows the output-enable pin without waiting for a clock. Both ports share one clock.

Top module: `dpr_sync_pipe_ram`

## Requirements
- R1: A port is selected at an edge only when `x_sel_n`=0 and `x_sel`=1 are sampled there. At an edge with any other pair, the port performs no write, loads no read data, and leaves its address counter unchanged.
- R2: Address and controls presented before edge k select the word that is accessed at edge k+1. A read result is visible on `x_rdata` right after edge k+1.
- R3: In a write, `x_be_n[0]`=0 enables bits 8:0 and `x_be_n[1]`=0 enables bits 17:9. A lane whose enable is 1 keeps its stored value.
- R4: With `x_clr_n`=1 and `x_ld_n`=0, the access uses the captured `x_addr`, and the counter takes that value.
- R5: With `x_clr_n`=1, `x_ld_n`=1 and `x_adv_n`=0, the access uses the counter plus one. The count wraps from DEPTH-1 to 0.
- R6: With `x_clr_n`=1, `x_ld_n`=1 and `x_adv_n`=1, the access uses the counter value unchanged, so the same word is accessed again.
- R7: `x_clr_n`=0 makes the access and the counter zero, whatever `x_ld_n` and `x_adv_n` are.
- R8: A write cycle leaves the port's output register unchanged, so the output keeps the last value read.
- R9: `x_drive` is 1 only when the port was selected at both of the two most recent edges and `x_oe_n` is 0 at that moment. Otherwise `x_drive`=0 and `x_rdata`=0. `x_oe_n` acts without a clock. After reset, both outputs are 0.
- R10: Both ports share one array, so a word written through one port is read back through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_sel_n | input | 1 | Port A select, must be 0 to select |
| a_sel | input | 1 | Port A select, must be 1 to select |
| a_we | input | 1 | Port A 1 = write, 0 = read |
| a_be_n | input | 2 | Port A lane enables, active low |
| a_ld_n | input | 1 | Port A load counter from address, active low |
| a_adv_n | input | 1 | Port A advance counter, active low |
| a_clr_n | input | 1 | Port A clear counter, active low |
| a_addr | input | AW | Port A external address |
| a_wdata | input | 18 | Port A write data |
| a_oe_n | input | 1 | Port A output enable, active low, unclocked |
| a_rdata | output | 18 | Port A read data, 0 when not driven |
| a_drive | output | 1 | Port A output-driven flag |
| b_sel_n | input | 1 | Port B select, must be 0 to select |
| b_sel | input | 1 | Port B select, must be 1 to select |
| b_we | input | 1 | Port B 1 = write, 0 = read |
| b_be_n | input | 2 | Port B lane enables, active low |
| b_ld_n | input | 1 | Port B load counter from address, active low |
| b_adv_n | input | 1 | Port B advance counter, active low |
| b_clr_n | input | 1 | Port B clear counter, active low |
| b_addr | input | AW | Port B external address |
| b_wdata | input | 18 | Port B write data |
| b_oe_n | input | 1 | Port B output enable, active low, unclocked |
| b_rdata | output | 18 | Port B read data, 0 when not driven |
| b_drive | output | 1 | Port B output-driven flag |

## Verification
The array is exercised with several kinds of traffic:
- Loaded single accesses.
- Write and read bursts that advance, stall and wrap at the top word.
- Clears that collide with a load.
- Single-lane writes.
- Writes on port A read back through port B.

Stall and advance produce distinct words, which separates the hold path from the increment path. A wrap write followed by a read of word zero shows whether the counter rolls over. Invalid select pairs issued mid-burst show whether a deselected cycle leaks into the array or the counter. Output-enable pulses, and a single selected cycle after a deselect, separate the drive gate from the data path.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   typedef enum logic [1:0] {
      DPR_NOP = 2'd0,
      DPR_RD  = 2'd1,
      DPR_WR  = 2'd2
   } dpr_op_e;

   typedef struct packed {
      logic clr;
      logic ld;
      logic adv;
   } dpr_cnt_ctl_t;

endpackage

// File: rtl/dpr_port_front.sv
module dpr_port_front
   import dpr_pkg::*;
#(
   parameter int DEPTH  = 4096,
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_n,
   input  logic             sel,
   input  logic             we,
   input  logic [LANES-1:0] be_n,
   input  logic             ld_n,
   input  logic             adv_n,
   input  logic             clr_n,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output dpr_op_e          op,
   output logic [AW-1:0]    acc_addr,
   output logic [LANES-1:0] lane_we,
   output logic [DW-1:0]    wdata_q,
   output logic             drive_ok
);

   logic             sel_q;
   logic             sel_d;
   logic             we_q;
   logic [LANES-1:0] be_q;
   dpr_cnt_ctl_t     ctl_q;
   logic [AW-1:0]    addr_q;
   logic [AW-1:0]    cnt;
   logic [AW-1:0]    inc;

   // input capture stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= 1'b0;
         sel_d   <= 1'b0;
         we_q    <= 1'b0;
         be_q    <= '0;
         ctl_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         cnt     <= '0;
      end else begin
         sel_q   <= !sel_n && sel;
         sel_d   <= sel_q;
         we_q    <= we;
         be_q    <= ~be_n;
         ctl_q   <= '{clr: !clr_n, ld: !ld_n, adv: !adv_n};
         addr_q  <= addr;
         wdata_q <= wdata;
         if (sel_q) cnt <= acc_addr;
      end
   end

   generate
      if (DEPTH == (1 << AW)) begin : g_pow2_wrap
         assign inc = cnt + 1'b1;
      end else begin : g_mod_wrap
         assign inc = (cnt == AW'(DEPTH - 1)) ? '0 : cnt + 1'b1;
      end
   endgenerate

   always_comb begin
      if (ctl_q.clr)      acc_addr = '0;
      else if (ctl_q.ld)  acc_addr = addr_q;
      else if (ctl_q.adv) acc_addr = inc;
      else                acc_addr = cnt;
   end

   always_comb begin
      if (!sel_q)    op = DPR_NOP;
      else if (we_q) op = DPR_WR;
      else           op = DPR_RD;
   end

   assign lane_we  = (op == DPR_WR) ? be_q : '0;
   assign drive_ok = sel_q && sel_d;

   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_q |=> $stable(cnt));
   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && !ctl_q.clr && ctl_q.ld) |=> (cnt == $past(addr_q)));
   assert_wrap_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && !ctl_q.clr && !ctl_q.ld && ctl_q.adv)
      |=> (cnt == AW'((int'($past(cnt)) + 1) % DEPTH)));
   assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && !ctl_q.clr && !ctl_q.ld && !ctl_q.adv) |=> $stable(cnt));
   assert_clr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && ctl_q.clr) |=> (cnt == '0));
   assert_deselect_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_q |=> !drive_ok);

endmodule

// File: rtl/dpr_lane_ram.sv
module dpr_lane_ram #(
   parameter int DEPTH = 4096,
   parameter int W     = 9,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_rd,
   input  logic          a_we,
   input  logic [AW-1:0] a_addr,
   input  logic [W-1:0]  a_wd,
   output logic [W-1:0]  a_q,
   input  logic          b_rd,
   input  logic          b_we,
   input  logic [AW-1:0] b_addr,
   input  logic [W-1:0]  b_wd,
   output logic [W-1:0]  b_q
);

   logic [W-1:0] mem [0:DEPTH-1];

   always_ff @(posedge clk) begin
      if (a_we) mem[a_addr] <= a_wd;
      if (b_we) mem[b_addr] <= b_wd;
   end

   // output registers, loaded only by reads (old data on same-edge write)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else begin
         if (a_rd) a_q <= mem[a_addr];
         if (b_rd) b_q <= mem[b_addr];
      end
   end

   assert_a_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !a_rd |=> $stable(a_q));
   assert_b_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !b_rd |=> $stable(b_q));

endmodule

// File: rtl/dpr_sync_pipe_ram.sv
module dpr_sync_pipe_ram
   import dpr_pkg::*;
#(
   parameter int DEPTH  = 4096,
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a_sel_n,
   input  logic             a_sel,
   input  logic             a_we,
   input  logic [LANES-1:0] a_be_n,
   input  logic             a_ld_n,
   input  logic             a_adv_n,
   input  logic             a_clr_n,
   input  logic [AW-1:0]    a_addr,
   input  logic [DW-1:0]    a_wdata,
   input  logic             a_oe_n,
   output logic [DW-1:0]    a_rdata,
   output logic             a_drive,
   input  logic             b_sel_n,
   input  logic             b_sel,
   input  logic             b_we,
   input  logic [LANES-1:0] b_be_n,
   input  logic             b_ld_n,
   input  logic             b_adv_n,
   input  logic             b_clr_n,
   input  logic [AW-1:0]    b_addr,
   input  logic [DW-1:0]    b_wdata,
   input  logic             b_oe_n,
   output logic [DW-1:0]    b_rdata,
   output logic             b_drive
);

   generate
      if (!(DEPTH == 4096 || DEPTH == 8192)) begin : g_bad_depth
         $error("dpr_sync_pipe_ram: DEPTH must be 4096 or 8192");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
         $error("dpr_sync_pipe_ram: LANES and LANE_W must be positive");
      end
   endgenerate

   dpr_op_e          op_a, op_b;
   logic [AW-1:0]    acc_a, acc_b;
   logic [LANES-1:0] lwe_a, lwe_b;
   logic [DW-1:0]    wd_a, wd_b;
   logic [DW-1:0]    q_a, q_b;
   logic             ok_a, ok_b;

   dpr_port_front #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_front_a (
      .clk(clk), .rst_n(rst_n), .sel_n(a_sel_n), .sel(a_sel), .we(a_we),
      .be_n(a_be_n), .ld_n(a_ld_n), .adv_n(a_adv_n), .clr_n(a_clr_n),
      .addr(a_addr), .wdata(a_wdata), .op(op_a), .acc_addr(acc_a),
      .lane_we(lwe_a), .wdata_q(wd_a), .drive_ok(ok_a)
   );

   dpr_port_front #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_front_b (
      .clk(clk), .rst_n(rst_n), .sel_n(b_sel_n), .sel(b_sel), .we(b_we),
      .be_n(b_be_n), .ld_n(b_ld_n), .adv_n(b_adv_n), .clr_n(b_clr_n),
      .addr(b_addr), .wdata(b_wdata), .op(op_b), .acc_addr(acc_b),
      .lane_we(lwe_b), .wdata_q(wd_b), .drive_ok(ok_b)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         dpr_lane_ram #(.DEPTH(DEPTH), .W(LANE_W)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .a_rd(op_a == DPR_RD), .a_we(lwe_a[g]), .a_addr(acc_a),
            .a_wd(wd_a[g*LANE_W +: LANE_W]), .a_q(q_a[g*LANE_W +: LANE_W]),
            .b_rd(op_b == DPR_RD), .b_we(lwe_b[g]), .b_addr(acc_b),
            .b_wd(wd_b[g*LANE_W +: LANE_W]), .b_q(q_b[g*LANE_W +: LANE_W])
         );
      end
   endgenerate

   assign a_drive = ok_a && !a_oe_n;
   assign b_drive = ok_b && !b_oe_n;
   assign a_rdata = a_drive ? q_a : '0;
   assign b_rdata = b_drive ? q_b : '0;

   assert_oe_gate_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
      a_oe_n |-> (a_rdata == '0 && !a_drive));
   assert_oe_gate_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
      b_oe_n |-> (b_rdata == '0 && !b_drive));
   assert_collide_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_a == DPR_WR && op_b == DPR_WR && (lwe_a & lwe_b) != '0) |-> (acc_a != acc_b));

endmodule

// File: tb/tb_dpr_sync_pipe_ram.sv
module tb_dpr_sync_pipe_ram;

   localparam int DEPTH = 4096;
   localparam int AW    = 12;
   localparam int DW    = 18;

   typedef struct {
      bit          sel_n, sel, we;
      logic [1:0]  be_n;
      bit          ld_n, adv_n, clr_n;
      logic [AW-1:0] addr;
      logic [DW-1:0] wd;
      bit          oe_n;
   } pin_t;

   typedef struct {
      int          due;
      int          port;
      bit          drv;
      logic [DW-1:0] data;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_sel_n = 1, a_sel = 0, a_we = 0, a_ld_n = 1, a_adv_n = 1, a_clr_n = 1, a_oe_n = 0;
   logic b_sel_n = 1, b_sel = 0, b_we = 0, b_ld_n = 1, b_adv_n = 1, b_clr_n = 1, b_oe_n = 0;
   logic [1:0] a_be_n = 2'b11, b_be_n = 2'b11;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic [DW-1:0] a_wdata = '0, b_wdata = '0;
   logic [DW-1:0] a_rdata, b_rdata;
   logic a_drive, b_drive;

   int checks = 0;
   int fails = 0;
   int edge_cnt = 0;
   bit done = 0;
   exp_t exp_q[$];

   // reference state
   pin_t pend[2];
   int   cnt[2];
   logic [DW-1:0] rdq[2];
   bit   s1[2], s2[2];
   logic [DW-1:0] mem[int];

   always #2 clk = ~clk;

   dpr_sync_pipe_ram #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n),
      .a_sel_n(a_sel_n), .a_sel(a_sel), .a_we(a_we), .a_be_n(a_be_n),
      .a_ld_n(a_ld_n), .a_adv_n(a_adv_n), .a_clr_n(a_clr_n), .a_addr(a_addr),
      .a_wdata(a_wdata), .a_oe_n(a_oe_n), .a_rdata(a_rdata), .a_drive(a_drive),
      .b_sel_n(b_sel_n), .b_sel(b_sel), .b_we(b_we), .b_be_n(b_be_n),
      .b_ld_n(b_ld_n), .b_adv_n(b_adv_n), .b_clr_n(b_clr_n), .b_addr(b_addr),
      .b_wdata(b_wdata), .b_oe_n(b_oe_n), .b_rdata(b_rdata), .b_drive(b_drive)
   );

   task automatic check(string tag, bit ok, logic [DW:0] act, logic [DW:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   function automatic pin_t p_idle();
      pin_t p;
      p.sel_n = 1; p.sel = 0; p.we = 0; p.be_n = 2'b11;
      p.ld_n = 1; p.adv_n = 1; p.clr_n = 1; p.addr = '0; p.wd = '0; p.oe_n = 0;
      return p;
   endfunction

   function automatic pin_t p_op(bit we, int addr, logic [DW-1:0] wd, logic [1:0] be_n,
                                 bit ld, bit adv, bit clr);
      pin_t p = p_idle();
      p.sel_n = 0; p.sel = 1; p.we = we; p.be_n = be_n;
      p.ld_n = !ld; p.adv_n = !adv; p.clr_n = !clr; p.addr = AW'(addr); p.wd = wd;
      return p;
   endfunction

   function automatic pin_t ldw(int addr, logic [DW-1:0] wd); return p_op(1, addr, wd, 2'b00, 1, 0, 0); endfunction
   function automatic pin_t incw(logic [DW-1:0] wd);          return p_op(1, 0, wd, 2'b00, 0, 1, 0); endfunction
   function automatic pin_t ldr(int addr);                    return p_op(0, addr, '0, 2'b11, 1, 0, 0); endfunction
   function automatic pin_t incr();                           return p_op(0, 0, '0, 2'b11, 0, 1, 0); endfunction
   function automatic pin_t hold();                           return p_op(0, 0, '0, 2'b11, 0, 0, 0); endfunction

   function automatic bit is_sel(pin_t p); return !p.sel_n && p.sel; endfunction

   task automatic step(pin_t pa, pin_t pb, string tag);
      pin_t np[2];
      int acc[2];
      exp_t e;
      @(negedge clk);
      a_sel_n = pa.sel_n; a_sel = pa.sel; a_we = pa.we; a_be_n = pa.be_n;
      a_ld_n = pa.ld_n; a_adv_n = pa.adv_n; a_clr_n = pa.clr_n; a_addr = pa.addr;
      a_wdata = pa.wd; a_oe_n = pa.oe_n;
      b_sel_n = pb.sel_n; b_sel = pb.sel; b_we = pb.we; b_be_n = pb.be_n;
      b_ld_n = pb.ld_n; b_adv_n = pb.adv_n; b_clr_n = pb.clr_n; b_addr = pb.addr;
      b_wdata = pb.wd; b_oe_n = pb.oe_n;
      np[0] = pa; np[1] = pb;
      // requirement model of the coming edge (accesses captured one edge earlier)
      for (int p = 0; p < 2; p++) begin
         if (!pend[p].clr_n)     acc[p] = 0;
         else if (!pend[p].ld_n) acc[p] = int'(pend[p].addr);
         else if (!pend[p].adv_n) acc[p] = (cnt[p] + 1) % DEPTH;
         else                    acc[p] = cnt[p];
      end
      for (int p = 0; p < 2; p++)
         if (is_sel(pend[p]) && !pend[p].we)
            rdq[p] = mem.exists(acc[p]) ? mem[acc[p]] : '0;
      for (int p = 0; p < 2; p++)
         if (is_sel(pend[p]) && pend[p].we) begin
            if (!mem.exists(acc[p])) mem[acc[p]] = '0;
            if (!pend[p].be_n[0]) mem[acc[p]][8:0]  = pend[p].wd[8:0];
            if (!pend[p].be_n[1]) mem[acc[p]][17:9] = pend[p].wd[17:9];
         end
      for (int p = 0; p < 2; p++) begin
         if (is_sel(pend[p])) cnt[p] = acc[p];
         s2[p] = s1[p];
         s1[p] = is_sel(np[p]);
         pend[p] = np[p];
         e.due  = edge_cnt + 1;
         e.port = p;
         e.drv  = s1[p] && s2[p] && !np[p].oe_n;
         e.data = e.drv ? rdq[p] : '0;
         e.tag  = tag;
         exp_q.push_back(e);
      end
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         edge_cnt++;
         #1;
         while (exp_q.size() > 0 && exp_q[0].due <= edge_cnt) begin
            automatic exp_t e = exp_q.pop_front();
            automatic logic act_d = (e.port == 0) ? a_drive : b_drive;
            automatic logic [DW-1:0] act_q = (e.port == 0) ? a_rdata : b_rdata;
            check($sformatf("%s port%0d", e.tag, e.port),
                  (act_d === e.drv) && (act_q === e.data),
                  {act_d, act_q}, {e.drv, e.data});
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < 2; p++) begin
         pend[p] = p_idle(); cnt[p] = 0; rdq[p] = '0; s1[p] = 0; s2[p] = 0;
      end
      repeat (3) @(posedge clk);
      #1;
      check("R9 reset a", a_drive === 1'b0 && a_rdata === '0, {a_drive, a_rdata}, '0);
      check("R9 reset b", b_drive === 1'b0 && b_rdata === '0, {b_drive, b_rdata}, '0);
      @(negedge clk);
      rst_n = 1;

      // R4/R5: loaded write burst on A
      step(ldw(10, 18'h0AAAA), p_idle(), "R4");
      step(incw(18'h11111), p_idle(), "R5");
      step(incw(18'h22222), p_idle(), "R5");
      step(incw(18'h33333), p_idle(), "R5");
      // R2/R4/R5/R6: read burst with a stall
      step(ldr(10), p_idle(), "R2");
      step(incr(), p_idle(), "R5");
      step(hold(), p_idle(), "R6");
      step(incr(), p_idle(), "R5");
      step(hold(), p_idle(), "R6");
      // R3: lane writes
      step(p_op(1, 10, 18'h3FFFF, 2'b10, 1, 0, 0), p_idle(), "R3");
      step(p_op(1, 11, 18'h3FFFF, 2'b01, 1, 0, 0), p_idle(), "R3");
      step(ldr(10), p_idle(), "R3");
      step(incr(), p_idle(), "R3");
      step(hold(), p_idle(), "R3");
      // R7: clear wins over load
      step(p_op(1, 7, 18'h0F0F0, 2'b00, 1, 0, 1), p_idle(), "R7");
      step(ldr(12), p_idle(), "R7");
      step(p_op(0, 33, '0, 2'b11, 1, 1, 1), p_idle(), "R7");
      step(hold(), p_idle(), "R7");
      // R5: wrap at the top word
      step(ldw(DEPTH - 1, 18'h12345), p_idle(), "R5");
      step(incw(18'h2BCDE), p_idle(), "R5");
      step(ldr(DEPTH - 1), p_idle(), "R5");
      step(incr(), p_idle(), "R5");
      step(hold(), p_idle(), "R5");
      // R8: write keeps output register
      step(ldr(12), p_idle(), "R8");
      step(ldw(13, 18'h01234), p_idle(), "R8");
      step(incw(18'h04321), p_idle(), "R8");
      step(hold(), p_idle(), "R8");
      // R1: invalid select pairs do nothing
      begin
         automatic pin_t bad = ldw(10, 18'h15555);
         bad.sel = 0;
         step(ldr(20), p_idle(), "R1");
         step(bad, p_idle(), "R1");
         bad = incw(18'h2AAAA); bad.sel_n = 1; bad.sel = 1;
         step(bad, p_idle(), "R1");
         step(ldr(10), p_idle(), "R1");
         step(incr(), p_idle(), "R1");
         step(hold(), p_idle(), "R1");
      end
      // R9: output enable and re-activation after deselect
      begin
         automatic pin_t r = hold();
         r.oe_n = 1;
         step(r, p_idle(), "R9");
         step(hold(), p_idle(), "R9");
         step(p_idle(), p_idle(), "R9");
         step(ldr(11), p_idle(), "R9");
         step(p_idle(), p_idle(), "R9");
         step(ldr(11), p_idle(), "R9");
         step(hold(), p_idle(), "R9");
         step(hold(), p_idle(), "R9");
      end
      // R10: cross-port traffic
      step(ldw(20, 18'h1C0DE), ldr(10), "R10");
      step(incw(18'h0BEEF), incr(), "R10");
      step(hold(), hold(), "R10");
      step(ldr(10), ldr(20), "R10");
      step(hold(), incr(), "R10");
      step(hold(), hold(), "R10");
      begin
         automatic pin_t bw = p_op(1, 30, 18'h3C3C3, 2'b01, 1, 0, 0);
         step(p_idle(), bw, "R10");
         step(ldr(30), hold(), "R10");
         step(hold(), hold(), "R10");
         step(hold(), hold(), "R10");
      end
      step(p_idle(), p_idle(), "R9");
      step(p_idle(), p_idle(), "R9");
      repeat (3) @(posedge clk);
      #2;
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule